// File: doc/BRIEF.md
# Split-Byte Sample Output Multiplexer

This block sits between a converter that produces 14-bit results and a narrow 8-bit output bus. Every result flagged valid is delayed by a fixed pipeline and then sent in two consecutive bus cycles. The first cycle carries the upper eight bits. The second carries the lower six bits, shifted to the top of the byte, with the two spare bits forced to zero. A phase flag is high during each upper-byte cycle, so a receiver can pair the two bytes back into one word without keeping its own count.

The bus can be switched to high impedance through an active-low output enable. The enable acts only on the pad drivers. The pipeline and the byte sequence keep running while the bus is released, so a host that shares the bus finds the stream at its proper position when it drives the enable low again. Results normally arrive at most once every two cycles. If two arrive back to back, the newer result takes over and the older one's lower byte is never sent.

Top module: `split_byte_out`

## Requirements
- R1: While reset is asserted the phase flag is high and, with the enable low, the bus shows 0x00. After reset no byte pair is produced until a result is presented with its valid strobe.
- R2: In a cycle where the phase flag is high, bus bits 7..0 carry bits 13..6 of the result.
- R3: In the cycle that follows a high-byte cycle (no newer result arriving), the phase flag is low, bus bits 7..2 carry result bits 5..0, and bus bits 1..0 are 0.
- R4: A result presented with valid high in cycle n shows its high byte in cycle n+3 and its low byte in cycle n+4. Pairing each high byte with the following low byte gives back the presented word.
- R5: The phase flag rises only when a delayed result reaches the output. Between results the bus holds the last low byte and the flag stays low.
- R6: When the enable input is high the bus is released to high impedance. When it is low the bus is driven.
- R7: The enable has no effect on the pipeline or on the byte phase. Bytes produced while the bus is released are lost, and the stream resumes in step afterwards.
- R8: When results arrive in consecutive cycles, the newer result's high byte replaces the older result's low byte, and the flag stays high.
- R9: A word presented with valid low is ignored: the bus keeps the value it would have shown without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously inside |
| smp_vld | input | 1 | Result valid strobe |
| smp_word | input | 14 | Conversion result |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 8 | Byte bus, high impedance while oe_n is high |
| hi_byte | output | 1 | High during high-byte cycles |

## Verification
A wrong stage count in the delay line moves every high byte off cycle n+3, so the first result after reset already shows it. A phase register that fails to toggle, or toggles on its own, breaks the pairing of bytes within the same result, and a swapped, shifted or unpadded bit field corrupts the reassembled word straight away. The sweep presents every 14-bit code, so any bit that is stuck or swapped shows up as a wrong reassembled word. Enable toggling in the middle of a pair shows whether the released bus disturbs the internal sequence: the next pair comes out of position.

// File: rtl/split_byte_pkg.sv
package split_byte_pkg;
  // Byte phase of the output register
  typedef enum logic {
    PH_LO = 1'b0,
    PH_HI = 1'b1
  } phase_e;
endpackage

// File: rtl/sbo_rst_sync.sv
module sbo_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/sbo_delay.sv
module sbo_delay #(
  parameter int W      = 14,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_word,
  output logic         out_vld,
  output logic [W-1:0] out_word
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic         v_d;
    logic [W-1:0] w_d;
    logic         v_r;
    logic [W-1:0] w_r;

    if (s == 0) begin : g_head
      assign v_d = in_vld;
      assign w_d = in_word;
    end else begin : g_link
      assign v_d = g_stage[s-1].v_r;
      assign w_d = g_stage[s-1].w_r;
    end

    // valid always advances; data register loads only behind a valid
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_r <= 1'b0;
        w_r <= '0;
      end else begin
        v_r <= v_d;
        if (v_d) begin
          w_r <= w_d;
        end
      end
    end
  end

  assign out_vld  = g_stage[STAGES-1].v_r;
  assign out_word = g_stage[STAGES-1].w_r;
endmodule

// File: rtl/sbo_phase.sv
module sbo_phase
  import split_byte_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_vld,
  input  logic [W-1:0] ld_word,
  output phase_e       phase_q,
  output logic [W-1:0] word_q
);
  phase_e phase_d;
  logic   word_en;

  // A delayed result opens a high-byte cycle; every other cycle is low.
  always_comb begin
    word_en = ld_vld;
    phase_d = PH_LO;
    if (ld_vld) begin
      phase_d = PH_HI;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HI;
      word_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (word_en) begin
        word_q <= ld_word;
      end
    end
  end
endmodule

// File: rtl/sbo_pack.sv
module sbo_pack
  import split_byte_pkg::*;
#(
  parameter int WORD_W = 14,
  parameter int BUS_W  = 8
) (
  input  phase_e              phase,
  input  logic [WORD_W-1:0]   word,
  output logic [BUS_W-1:0]    bus
);
  localparam int LO_W  = WORD_W - BUS_W;
  localparam int PAD_W = BUS_W - LO_W;

  logic [BUS_W-1:0] hi_field;
  logic [BUS_W-1:0] lo_field;

  assign hi_field = word[WORD_W-1 -: BUS_W];

  if (PAD_W > 0) begin : g_pad
    assign lo_field = {word[LO_W-1:0], {PAD_W{1'b0}}};
  end else begin : g_nopad
    assign lo_field = word[LO_W-1:0];
  end

  always_comb begin
    bus = lo_field;
    if (phase == PH_HI) begin
      bus = hi_field;
    end
  end
endmodule

// File: rtl/split_byte_out.sv
module split_byte_out
  import split_byte_pkg::*;
#(
  parameter int WORD_W  = 14,
  parameter int BUS_W   = 8,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [WORD_W-1:0] smp_word,
  input  logic              oe_n,
  output logic [BUS_W-1:0]  dout,
  output logic              hi_byte
);
  localparam int DLY_STAGES = LATENCY - 1;

  if (WORD_W <= BUS_W || WORD_W > 2 * BUS_W || LATENCY < 2) begin : g_bad_cfg
    initial $error("split_byte_out: unsupported parameter set");
  end

  logic              rst_q_n;
  logic              dly_vld;
  logic [WORD_W-1:0] dly_word;
  phase_e            phase_q;
  logic [WORD_W-1:0] out_word;
  logic [BUS_W-1:0]  bus_drv;

  sbo_rst_sync #(.SYNC_STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  sbo_delay #(.W(WORD_W), .STAGES(DLY_STAGES)) u_dly (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .in_vld   (smp_vld),
    .in_word  (smp_word),
    .out_vld  (dly_vld),
    .out_word (dly_word)
  );

  sbo_phase #(.W(WORD_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .ld_vld  (dly_vld),
    .ld_word (dly_word),
    .phase_q (phase_q),
    .word_q  (out_word)
  );

  sbo_pack #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_pack (
    .phase (phase_q),
    .word  (out_word),
    .bus   (bus_drv)
  );

  assign hi_byte = (phase_q == PH_HI);
  assign dout    = oe_n ? {BUS_W{1'bz}} : bus_drv;
endmodule

// File: rtl/sbo_checker.sv
module sbo_checker #(
  parameter int WORD_W  = 14,
  parameter int BUS_W   = 8,
  parameter int LATENCY = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_vld,
  input logic [WORD_W-1:0] smp_word,
  input logic              oe_n,
  input logic [BUS_W-1:0]  dout,
  input logic              hi_byte
);
  localparam int LO_W  = WORD_W - BUS_W;
  localparam int PAD_W = BUS_W - LO_W;

  logic [LATENCY-1:0] ck_v;
  logic [WORD_W-1:0]  ck_w [LATENCY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_v <= '0;
      for (int i = 0; i < LATENCY; i++) ck_w[i] <= '0;
    end else begin
      ck_v    <= {ck_v[LATENCY-2:0], smp_vld};
      ck_w[0] <= smp_word;
      for (int i = 1; i < LATENCY; i++) ck_w[i] <= ck_w[i-1];
    end
  end

  // R4: a result accepted LATENCY edges ago is now in its high-byte cycle
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ck_v[LATENCY-1] |-> hi_byte);

  // R2: high byte carries the upper result bits
  a_r2_high_field: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_v[LATENCY-1] && !oe_n) |-> (dout == ck_w[LATENCY-1][WORD_W-1 -: BUS_W]));

  // R3: the following cycle carries the lower bits, padded with zeros
  a_r3_low_field: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_v[LATENCY-1] && !ck_v[LATENCY-2]) |=>
      (!hi_byte && (oe_n ||
        dout == {$past(ck_w[LATENCY-1][LO_W-1:0]), {PAD_W{1'b0}}})));

  // R5: the flag rises only for a delayed result
  a_r5_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_byte) |-> ck_v[LATENCY-1]);
endmodule

bind split_byte_out sbo_checker #(
  .WORD_W (WORD_W),
  .BUS_W  (BUS_W),
  .LATENCY(LATENCY)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .smp_vld  (smp_vld),
  .smp_word (smp_word),
  .oe_n     (oe_n),
  .dout     (dout),
  .hi_byte  (hi_byte)
);

// File: tb/split_byte_out_tb.sv
`timescale 1ns/1ps
module split_byte_out_tb;
  logic        clk;
  logic        rst_n;
  logic        smp_vld;
  logic [13:0] smp_word;
  logic        oe_n;
  wire  [7:0]  dout;
  logic        hi_byte;

  int checks = 0;
  int fails  = 0;

  // weak keeper makes a released bus read as 0xA5
  assign (weak0, weak1) dout = 8'hA5;

  split_byte_out u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_word(smp_word),
    .oe_n(oe_n), .dout(dout), .hi_byte(hi_byte)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural model
  logic        d1, d2;
  logic [13:0] w1, w2, mw;
  logic        mhi;
  logic [7:0]  rec_hi;
  logic        have_hi;

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_ports();
    logic [7:0] exp;
    string tag;
    if (oe_n) begin
      exp = 8'hA5; tag = "R6 released bus / R7";
    end else if (mhi) begin
      exp = mw[13:6]; tag = "R2 high byte / R8";
    end else begin
      exp = {mw[5:0], 2'b00}; tag = "R3 low byte / R5 / R9";
    end
    expect_eq(tag, {24'd0, dout}, {24'd0, exp});
    expect_eq("R5 phase flag", {31'd0, hi_byte}, {31'd0, mhi});
    if (oe_n) begin
      have_hi = 1'b0;
    end else if (hi_byte) begin
      rec_hi = dout; have_hi = 1'b1;
    end else if (have_hi) begin
      expect_eq("R4 reassembled word", {18'd0, rec_hi, dout[7:2]}, {18'd0, mw});
      have_hi = 1'b0;
    end
  endtask

  task automatic cyc(input logic v, input logic [13:0] w, input logic oen);
    smp_vld = v; smp_word = w; oe_n = oen;
    @(posedge clk);
    if (d2) begin mw = w2; mhi = 1'b1; end else mhi = 1'b0;
    d2 = d1; if (d1) w2 = w1;
    d1 = v;  if (v)  w1 = w;
    @(negedge clk);
    check_ports();
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_vld = 1'b0; smp_word = '0; oe_n = 1'b0;
    d1 = 0; d2 = 0; w1 = 0; w2 = 0; mw = 0; mhi = 1'b1; have_hi = 1'b0; rec_hi = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_eq("R1 reset bus", {24'd0, dout}, 32'd0);
    expect_eq("R1 reset flag", {31'd0, hi_byte}, 32'd1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    mhi = 1'b0;
    // R1: no pair emerges without a valid
    check_ports();
    cyc(0, 14'h1234, 0);

    // R2 R3 R4: directed extremes, one result every two cycles
    cyc(1, 14'h3FFF, 0); cyc(0, 14'h0000, 0);
    cyc(1, 14'h0000, 0); cyc(0, 14'h3FFF, 0);
    cyc(1, 14'h2AAA, 0); cyc(0, 14'h0000, 0);
    cyc(1, 14'h1555, 0); cyc(0, 14'h0000, 0);
    // R5 R9: long gap with garbage words and valid low
    for (int i = 0; i < 6; i++) cyc(0, 14'h3C3C ^ 14'(i), 0);
    // R8: back-to-back results
    cyc(1, 14'h0ABC, 0); cyc(1, 14'h3123, 0); cyc(0, 0, 0);
    cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
    // R6 R7: release the bus around a pair, then resume
    cyc(1, 14'h2D0F, 0); cyc(0, 0, 0); cyc(1, 14'h0F2D, 0); cyc(0, 0, 1);
    cyc(0, 0, 1); cyc(0, 0, 0); cyc(1, 14'h1E1E, 1); cyc(0, 0, 0);
    cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);

    // R2 R3 R4 R7: every 14-bit code, enable released now and then
    for (int w = 0; w < 16384; w++) begin
      cyc(1, 14'(w), (w % 97) == 5);
      cyc(0, ~14'(w), (w % 89) == 7);
    end
    for (int i = 0; i < 4; i++) cyc(0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule